// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a virtual page to a real page by searching a hashed page table that sits in ordinary memory. A caller gives it a 24-bit virtual segment identifier, the 28-bit offset of the access within its 256 MB segment, and a flag that marks the access as a store. The caller also supplies the table base address and the table mask. The walker hashes the segment identifier with the page index to choose a group of entries. It reads the first word of each entry in that group in turn, and it fetches the second word only for an entry that matches. If the first group holds no match, the walker searches a second group chosen by the complemented hash.

On a hit, the walker sets the referenced flag in the entry's second word. On a store it also sets the changed flag. It writes that word back to memory only when its value has changed. It then returns the real address, the entry's two protection bits, and a write-allowed flag. The write-allowed flag is cleared for loads, so the first later store to the page walks the table again and marks the page changed. On a miss in both groups, the walker reports done with hit low. Deciding whether an access is permitted is left to the caller.

Memory is reached through a request channel with valid and ready signals. Reads return on a separate response strobe, and writes complete when the request is accepted.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `done` and `mem_req_valid` are low.
- R2: The first read of a walk fetches word 0 of entry 0 of the primary group. Its address is `tbl_base | ((H << 6) & tbl_mask)`, where H = vsid XOR seg_off[27:12], zero-extended to 32 bits.
- R3: Within a group, the walker reads word 0 of the entries in ascending order, entry i at group+8*i. It reads word 1 (group+8*i+4) only for the entry that matched, so a hit at primary entry k costs k+2 reads.
- R4: An entry matches only if all of these hold in word 0:
  - bit 31 (valid) is 1;
  - bit 6 equals the current pass (0 for the primary group, 1 for the secondary group);
  - bits 30:7 equal vsid;
  - bits 5:0 equal seg_off[27:22].
- R5: When no entry in the primary group matches, the walker searches the secondary group at `tbl_base | ((~H << 6) & tbl_mask)`. A hit at secondary entry k costs 8+k+2 reads.
- R6: A miss in both groups takes exactly 16 reads and no write. It ends with `done` high, `hit` low, and `real_addr`, `pp` and `wr_ok` all zero.
- R7: On a hit, the walker sets bit 8 (referenced) of word 1, and sets bit 7 (changed) as well when `is_store` is high. It writes the new word to word 1's address only if the word differs from the value read; otherwise it issues no write.
- R8: On a hit, `wr_ok` equals `is_store`.
- R9: On a hit, `real_addr` is {word1[31:12], seg_off[11:0]} and `pp` is word1[1:0].
- R10: A request is held stable until it is accepted. At most one read is outstanding at a time. A `start` pulse during a walk has no effect on that walk.
- R11: `done` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk; accepted only while idle |
| vsid | input | 24 | Virtual segment identifier |
| seg_off | input | 28 | Offset of the access within its segment |
| is_store | input | 1 | The access is a store |
| tbl_base | input | 32 | Table base address, aligned to the table size |
| tbl_mask | input | 32 | Mask applied to the group byte offset |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one-cycle pulse) |
| hit | output | 1 | A matching entry was found |
| real_addr | output | 32 | Translated real address |
| pp | output | 2 | Protection bits of the entry |
| wr_ok | output | 1 | Write permission may be cached for this page |

## Verification
The assertions check these rules on every cycle:
- a request stays stable while it waits for acceptance;
- a new request never overlaps a read that is still outstanding;
- every write-back carries the referenced bit and targets word 1;
- `done` lasts one cycle;
- a miss leaves all result fields zero.

Other properties depend on table contents and need the bench's scenarios to show them:
- the hash arithmetic, the group addresses and the effect of the mask;
- ascending scan order, the match rule, including decoy entries with the wrong pass flag, a clear valid bit or a wrong tag;
- the fall-through to the secondary group;
- whether a write-back happens at all.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int VSID_W  = 24;
    localparam int OFF_W   = 28;
    localparam int WORD_W  = 32;
    localparam int PG_HI   = 27;
    localparam int PG_LO   = 12;
    localparam int API_W   = 6;

    localparam int W0_VALID = 31;
    localparam int W0_SEC   = 6;
    localparam int W1_REF   = 8;
    localparam int W1_CHG   = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_TAG,
        S_WT_TAG,
        S_RD_PTE,
        S_WT_PTE,
        S_WRBACK,
        S_DONE
    } walk_st_e;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int GRP_SHIFT = 6
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [PG_HI:PG_LO] pg_idx,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] pri_addr,
    output logic [WORD_W-1:0] sec_addr,
    output logic [WORD_W-2:0] tag
);
    localparam int PG_W = PG_HI - PG_LO + 1;

    logic [WORD_W-1:0] hash;

    always_comb begin
        hash = {{(WORD_W-VSID_W){1'b0}}, vsid}
             ^ {{(WORD_W-PG_W){1'b0}}, pg_idx};
        pri_addr = base | ((hash << GRP_SHIFT) & mask);
        sec_addr = base | (((~hash) << GRP_SHIFT) & mask);
        tag      = {vsid, 1'b0, pg_idx[PG_HI:PG_HI-API_W+1]};
    end

endmodule

// File: rtl/hpt_match.sv
module hpt_match
    import hpt_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-2:0] tag,
    input  logic              pass,
    output logic              match
);
    logic valid_ok;
    logic pass_ok;
    logic tag_ok;

    always_comb begin
        valid_ok = w0[W0_VALID];
        pass_ok  = (w0[W0_SEC] == pass);
        tag_ok   = (w0[WORD_W-2:W0_SEC+1] == tag[WORD_W-2:W0_SEC+1])
                && (w0[W0_SEC-1:0] == tag[W0_SEC-1:0]);
        match    = valid_ok && pass_ok && tag_ok;
    end

endmodule

// File: rtl/hpt_pte_update.sv
module hpt_pte_update
    import hpt_pkg::*;
(
    input  logic [WORD_W-1:0] w1_in,
    input  logic              store,
    input  logic [PG_LO-1:0]  page_off,
    output logic [WORD_W-1:0] w1_new,
    output logic              need_wb,
    output logic [WORD_W-1:0] raddr,
    output logic [1:0]        prot
);
    always_comb begin
        w1_new         = w1_in;
        w1_new[W1_REF] = 1'b1;
        if (store) begin
            w1_new[W1_CHG] = 1'b1;
        end
        need_wb = (w1_new != w1_in);
        raddr   = {w1_in[WORD_W-1:PG_LO], page_off};
        prot    = w1_in[1:0];
    end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8,
    parameter int ENTRY_BYTES   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VSID_W-1:0]   vsid,
    input  logic [OFF_W-1:0]    seg_off,
    input  logic                is_store,
    input  logic [WORD_W-1:0]   tbl_base,
    input  logic [WORD_W-1:0]   tbl_mask,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_we,
    output logic [WORD_W-1:0]   mem_req_addr,
    output logic [WORD_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_rdata,
    output logic                done,
    output logic                hit,
    output logic [WORD_W-1:0]   real_addr,
    output logic [1:0]          pp,
    output logic                wr_ok
);
    localparam int IDX_W     = $clog2(GROUP_ENTRIES);
    localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);
    localparam int GRP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
    localparam logic [WORD_W-1:0] W1_OFS   = WORD_W'(ENTRY_BYTES / 2);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(GROUP_ENTRIES - 1);

    typedef struct packed {
        walk_st_e          st;
        logic              pass;
        logic [IDX_W-1:0]  idx;
        logic [VSID_W-1:0] vsid;
        logic [OFF_W-1:0]  off;
        logic              store;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] w1;
        logic              hit;
        logic [WORD_W-1:0] raddr;
        logic [1:0]        pp;
        logic              wr_ok;
    } walk_t;

    walk_t q, d;

    logic [WORD_W-1:0] pri_addr;
    logic [WORD_W-1:0] sec_addr;
    logic [WORD_W-2:0] tag;
    logic              ent_match;
    logic [WORD_W-1:0] w1_new;
    logic              need_wb;
    logic [WORD_W-1:0] pte_raddr;
    logic [1:0]        pte_prot;
    logic [WORD_W-1:0] grp_addr;
    logic [WORD_W-1:0] ent_addr;

    hpt_hash #(.GRP_SHIFT(GRP_SHIFT)) u_hash (
        .vsid     (q.vsid),
        .pg_idx   (q.off[PG_HI:PG_LO]),
        .base     (q.base),
        .mask     (q.mask),
        .pri_addr (pri_addr),
        .sec_addr (sec_addr),
        .tag      (tag)
    );

    hpt_match u_match (
        .w0    (mem_rsp_rdata),
        .tag   (tag),
        .pass  (q.pass),
        .match (ent_match)
    );

    hpt_pte_update u_upd (
        .w1_in    (mem_rsp_rdata),
        .store    (q.store),
        .page_off (q.off[PG_LO-1:0]),
        .w1_new   (w1_new),
        .need_wb  (need_wb),
        .raddr    (pte_raddr),
        .prot     (pte_prot)
    );

    always_comb begin
        grp_addr = q.pass ? sec_addr : pri_addr;
        ent_addr = grp_addr | ({{(WORD_W-IDX_W){1'b0}}, q.idx} << ENT_SHIFT);
    end

    always_comb begin
        d = q;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = ent_addr;
        mem_req_wdata = q.w1;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st    = S_RD_TAG;
                    d.pass  = 1'b0;
                    d.idx   = '0;
                    d.vsid  = vsid;
                    d.off   = seg_off;
                    d.store = is_store;
                    d.base  = tbl_base;
                    d.mask  = tbl_mask;
                    d.w1    = '0;
                    d.hit   = 1'b0;
                    d.raddr = '0;
                    d.pp    = '0;
                    d.wr_ok = 1'b0;
                end
            end
            S_RD_TAG: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    d.st = S_WT_TAG;
                end
            end
            S_WT_TAG: begin
                if (mem_rsp_valid) begin
                    if (ent_match) begin
                        d.st = S_RD_PTE;
                    end else if (q.idx == IDX_LAST) begin
                        if (!q.pass) begin
                            d.pass = 1'b1;
                            d.idx  = '0;
                            d.st   = S_RD_TAG;
                        end else begin
                            d.st = S_DONE;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = S_RD_TAG;
                    end
                end
            end
            S_RD_PTE: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ent_addr | W1_OFS;
                if (mem_req_ready) begin
                    d.st = S_WT_PTE;
                end
            end
            S_WT_PTE: begin
                if (mem_rsp_valid) begin
                    d.w1    = w1_new;
                    d.hit   = 1'b1;
                    d.raddr = pte_raddr;
                    d.pp    = pte_prot;
                    d.wr_ok = q.store;
                    d.st    = need_wb ? S_WRBACK : S_DONE;
                end
            end
            S_WRBACK: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = ent_addr | W1_OFS;
                if (mem_req_ready) begin
                    d.st = S_DONE;
                end
            end
            S_DONE: begin
                d.st = S_IDLE;
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign done      = (q.st == S_DONE);
    assign hit       = q.hit;
    assign real_addr = q.raddr;
    assign pp        = q.pp;
    assign wr_ok     = q.wr_ok;

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_we,
    input logic [31:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic        mem_rsp_valid,
    input logic        done,
    input logic        hit,
    input logic [31:0] real_addr,
    input logic [1:0]  pp,
    input logic        wr_ok
);
    logic rd_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_open <= 1'b0;
        end else if (mem_req_valid && mem_req_ready && !mem_req_we) begin
            rd_open <= 1'b1;
        end else if (mem_rsp_valid) begin
            rd_open <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata)); // R10

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rd_open); // R10

    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_wdata[8] && mem_req_addr[2:0] == 3'b100); // R7

    AST_TAG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done && !hit |-> real_addr == 32'h0 && pp == 2'b00 && !wr_ok); // R6

endmodule

bind hpt_walker hpt_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .hit           (hit),
    .real_addr     (real_addr),
    .pp            (pp),
    .wr_ok         (wr_ok)
);

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] vsid = '0;
    logic [27:0] seg_off = '0;
    logic        is_store = 1'b0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic [31:0] tbl_mask = 32'h000F_FFC0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        done;
    logic        hit;
    logic [31:0] real_addr;
    logic [1:0]  pp;
    logic        wr_ok;

    always #2.5 clk = ~clk;

    hpt_walker u_hpt_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .seg_off(seg_off),
        .is_store(is_store), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done(done), .hit(hit),
        .real_addr(real_addr), .pp(pp), .wr_ok(wr_ok)
    );

    typedef struct {
        logic        hit;
        logic [31:0] raddr;
        logic [1:0]  pp;
        logic        wr_ok;
        logic [31:0] first_addr;
        int          reads;
        int          writes;
        int          rd_base;
        int          wr_base;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log[$];
    int          wr_cnt = 0;
    int          rdy_ctr = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    logic        prev_done = 1'b0;

    assign mem_req_ready = (rdy_ctr % 3) != 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model
    always @(posedge clk) begin
        rdy_ctr <= rdy_ctr + 1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt++;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
                rd_log.push_back(mem_req_addr);
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (prev_done) begin
            chk(!done, "R11 done pulse", {31'b0, done}, 32'h0);
        end
        prev_done <= done;
        if (done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(hit == e.hit, "R4/R6 hit", {31'b0, hit}, {31'b0, e.hit});
                chk(real_addr == e.raddr, "R9 real_addr", real_addr, e.raddr);
                chk(pp == e.pp, "R9 pp", {30'b0, pp}, {30'b0, e.pp});
                chk(wr_ok == e.wr_ok, "R8 wr_ok", {31'b0, wr_ok}, {31'b0, e.wr_ok});
                chk(rd_log.size() > e.rd_base && rd_log[e.rd_base] == e.first_addr,
                    "R2 first read address",
                    (rd_log.size() > e.rd_base) ? rd_log[e.rd_base] : 32'hFFFF_FFFF, e.first_addr);
                chk(rd_log.size() - e.rd_base == e.reads, "R3/R5 read count",
                    32'(rd_log.size() - e.rd_base), 32'(e.reads));
                chk(wr_cnt - e.wr_base == e.writes, "R7 write count",
                    32'(wr_cnt - e.wr_base), 32'(e.writes));
            end
        end
    end

    function automatic logic [31:0] hsh(input logic [23:0] v, input logic [27:0] o);
        return {8'b0, v} ^ {16'b0, o[27:12]};
    endfunction

    function automatic logic [31:0] pri_grp(input logic [23:0] v, input logic [27:0] o);
        return tbl_base | ((hsh(v, o) << 6) & tbl_mask);
    endfunction

    function automatic logic [31:0] sec_grp(input logic [23:0] v, input logic [27:0] o);
        return tbl_base | (((~hsh(v, o)) << 6) & tbl_mask);
    endfunction

    function automatic logic [31:0] mk_w0(input bit valid, input logic [23:0] v, input bit sec, input logic [5:0] api);
        return {valid, v, sec, api};
    endfunction

    function automatic logic [31:0] mk_w1(input logic [19:0] rpn, input bit r, input bit c, input logic [1:0] p);
        return {rpn, 3'b0, r, c, 5'b0, p};
    endfunction

    task automatic put(input logic [31:0] grp, input int idx, input logic [31:0] w0, input logic [31:0] w1);
        mem[grp + 32'(idx * 8)]     = w0;
        mem[grp + 32'(idx * 8) + 4] = w1;
    endtask

    // driver: push expectation, launch walk, wait for the monitor to consume it
    task automatic walk(input logic [23:0] v, input logic [27:0] o, input bit st,
                        input bit e_hit, input logic [31:0] e_w1, input int e_reads,
                        input int e_writes, input bit glitch);
        exp_t e;
        e.hit        = e_hit;
        e.raddr      = e_hit ? {e_w1[31:12], o[11:0]} : 32'h0;
        e.pp         = e_hit ? e_w1[1:0] : 2'b00;
        e.wr_ok      = e_hit && st;
        e.first_addr = pri_grp(v, o);
        e.reads      = e_reads;
        e.writes     = e_writes;
        e.rd_base    = rd_log.size();
        e.wr_base    = wr_cnt;
        sb.push_back(e);
        @(negedge clk);
        vsid = v; seg_off = o; is_store = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            // R10: a start pulse mid-walk with other inputs must not disturb it
            repeat (3) @(negedge clk);
            vsid = ~v; seg_off = ~o; is_store = ~st; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] va;
        logic [27:0] oa;
        logic [31:0] ga;
        logic [31:0] gs;
        logic [31:0] w1a;

        repeat (3) @(negedge clk);
        chk(!done, "R1 done after reset", {31'b0, done}, 32'h0);
        chk(!mem_req_valid, "R1 req_valid after reset", {31'b0, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Primary hit at entry 3 behind three decoys (R4)
        va = 24'h12_3456; oa = 28'hABC_D123;
        ga = pri_grp(va, oa);
        w1a = mk_w1(20'h7_1234, 1'b0, 1'b0, 2'd2);
        put(ga, 0, mk_w0(1'b0, va, 1'b0, oa[27:22]), 32'h0);
        put(ga, 1, mk_w0(1'b1, va, 1'b1, oa[27:22]), 32'h0);
        put(ga, 2, mk_w0(1'b1, va, 1'b0, oa[27:22] ^ 6'h1), 32'h0);
        put(ga, 3, mk_w0(1'b1, va, 1'b0, oa[27:22]), w1a);
        walk(va, oa, 1'b0, 1'b1, w1a, 5, 1, 1'b0);
        chk(mem[ga + 28] == (w1a | 32'h100), "R7 load sets referenced only", mem[ga + 28], w1a | 32'h100);

        // Referenced already set: no write-back (R7)
        walk(va, oa, 1'b0, 1'b1, w1a, 5, 0, 1'b0);

        // Store sets changed bit; mid-walk start ignored (R10)
        walk(va, oa, 1'b1, 1'b1, w1a, 5, 1, 1'b1);
        chk(mem[ga + 28] == (w1a | 32'h180), "R7 store sets changed", mem[ga + 28], w1a | 32'h180);
        walk(va, oa, 1'b1, 1'b1, w1a, 5, 0, 1'b0);

        // Secondary hit at entry 6 (R5) with pass-flag decoys in both groups (R4)
        mem.delete();
        va = 24'h00_0F0F; oa = 28'h456_7ABC;
        ga = pri_grp(va, oa);
        gs = sec_grp(va, oa);
        w1a = mk_w1(20'hC_AFE0, 1'b1, 1'b0, 2'd1);
        put(ga, 0, mk_w0(1'b1, va, 1'b1, oa[27:22]), 32'h0);
        put(gs, 5, mk_w0(1'b1, va, 1'b0, oa[27:22]), 32'h0);
        put(gs, 6, mk_w0(1'b1, va, 1'b1, oa[27:22]), w1a);
        walk(va, oa, 1'b0, 1'b1, w1a, 16, 0, 1'b0);
        chk(rd_log[rd_log.size() - 8] == gs, "R5 secondary group address", rd_log[rd_log.size() - 8], gs);

        // Complete miss (R6)
        mem.delete();
        walk(24'h55_5555, 28'h123_4567, 1'b1, 1'b0, 32'h0, 16, 0, 1'b0);

        // Last entry of primary group, store (R3, R7)
        va = 24'hAB_CDEF; oa = 28'hFED_C987;
        ga = pri_grp(va, oa);
        w1a = mk_w1(20'h0_0042, 1'b1, 1'b0, 2'd3);
        put(ga, 7, mk_w0(1'b1, va, 1'b0, oa[27:22]), w1a);
        walk(va, oa, 1'b1, 1'b1, w1a, 9, 1, 1'b0);
        chk(rd_log[rd_log.size() - 1] == ga + 60, "R3 word1 address of entry 7", rd_log[rd_log.size() - 1], ga + 60);

        // Narrow mask folds the hash (R2)
        mem.delete();
        tbl_base = 32'h0020_0000; tbl_mask = 32'h0000_0FC0;
        va = 24'hFF_F3C1; oa = 28'h89A_B00C;
        ga = pri_grp(va, oa);
        w1a = mk_w1(20'h3_3333, 1'b0, 1'b0, 2'd0);
        put(ga, 0, mk_w0(1'b1, va, 1'b0, oa[27:22]), w1a);
        walk(va, oa, 1'b0, 1'b1, w1a, 2, 1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule